// File: doc/BRIEF.md
# Hotplug Slot Event Register Bank

This block keeps, for each of several buses, two bitmaps of up to 32 slots: slots with a pending insertion and slots with a pending removal. A platform agent reports each slot event on a one-cycle event port, giving the direction, bus, slot and whether the event happened while the system was running. Firmware reads the bitmaps through a small 32-bit register port, chooses the bus with a select register, and acknowledges a removal by writing an eject mask. The block then pulses an eject output with the bus and slot that the agent must release.

Every accepted running-time event sets a general-purpose event status flag, and the interrupt output follows that flag gated by an enable flag. A parameter selects between a bridge-capable mode, with several buses and clear-on-read insertion bits, and a legacy single-bus mode with a shorter register window and sticky insertion bits. A platform reset pulse makes the block release every pending removal, one slot per cycle.

Top module: `slot_evt_bank`

## Requirements
- R1: Byte offsets decode as 0x00 pending-insert bitmap, 0x04 pending-remove bitmap, 0x0C removable mask (the inverse of the selected bus's `fixed_slots` field, bus b at bits b*32 upward), 0x10 bus select, 0x18 event status (bit 1), 0x1C event enable (bit 1). Per-bus registers read zero when the select is out of range, undecoded offsets read zero, and writes to read-only offsets change nothing.
- R2: A read of offset 0x08 returns zero.
- R3: With `BRIDGE`=1 a read of 0x00 returns the selected bus's insert bitmap and clears it; with `BRIDGE`=0 the bitmap is left unchanged by the read.
- R4: With `BRIDGE`=0 the window ends below 0x0F: offset 0x10 reads zero, writes to it are ignored so the select stays 0, and only events for bus 0 are accepted.
- R5: A running-time insertion sets the slot's bit in the insert bitmap; a removal sets it in the remove bitmap; either sets status bit 1 (value 2).
- R6: An insertion with `evt_hot`=0 changes no bitmap and no status.
- R7: A write to 0x08 picks the lowest set bit of the data, clears that slot in both bitmaps of the selected bus and pulses `eject_valid` for one cycle with that bus and slot; zero data does nothing.
- R8: An eject write is ignored when the select value is at or above `NUM_BUS`.
- R9: An event for a bus with no valid index pulses `evt_err` for one cycle and changes no state.
- R10: `irq` is high exactly when status bit 1 and enable bit 1 are both set; writing 1 to status bit 1 clears it.
- R11: A `plat_reset` pulse releases every pending removal, one per cycle, lowest bus first and lowest slot within a bus, pulsing the eject outputs for each and clearing both bitmap bits.
- R12: After reset all bitmaps, the select, status, enable, `irq`, `evt_err` and `eject_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte offset of the access |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid the cycle after `reg_rd` |
| evt_valid | input | 1 | Slot event strobe |
| evt_remove | input | 1 | 1 for removal, 0 for insertion |
| evt_hot | input | 1 | 1 when the event happens at running time |
| evt_bus | input | $clog2(NUM_BUS)+1 | Bus index of the event |
| evt_slot | input | $clog2(NUM_SLOT) | Slot number of the event |
| evt_err | output | 1 | One-cycle pulse for an event on an invalid bus |
| fixed_slots | input | NUM_BUS*NUM_SLOT | Per-bus, per-slot non-removable flags |
| plat_reset | input | 1 | Starts the release of all pending removals |
| eject_valid | output | 1 | One-cycle eject pulse |
| eject_bus | output | $clog2(NUM_BUS) | Bus of the ejected slot |
| eject_slot | output | $clog2(NUM_SLOT) | Ejected slot |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches every cycle that invalid-bus events and only those raise the error pulse, that eject pulses come only from an eject write or the reset drain, that zero eject data never ejects, that the feature offset and the unreachable offsets always read zero, and that the interrupt never rises without a preceding access or event. The scenarios show what needs history: the contents of the bitmaps, clear-on-read against sticky insertion bits, lowest-bit selection on eject, the effect of the bus select and its out-of-range case, cold insertions, and the order of the ejects during the reset drain, compared between a bridge-capable and a legacy instance driven with the same stimulus.

// File: rtl/slot_evt_pkg.sv
package slot_evt_pkg;
    typedef enum logic [2:0] {
        RG_NONE,
        RG_UP,
        RG_DOWN,
        RG_EJ,
        RG_RMV,
        RG_SEL,
        RG_STS,
        RG_EN
    } reg_id_e;

    localparam int OFS_UP   = 'h00;
    localparam int OFS_DOWN = 'h04;
    localparam int OFS_EJ   = 'h08;
    localparam int OFS_RMV  = 'h0C;
    localparam int OFS_SEL  = 'h10;
    localparam int OFS_STS  = 'h18;
    localparam int OFS_EN   = 'h1C;
    localparam int WIN_BRIDGE = 'h14;
    localparam int WIN_LEGACY = 'h0F;
    localparam int STS_BIT    = 1;
endpackage

// File: rtl/slot_evt_decode.sv
module slot_evt_decode
    import slot_evt_pkg::*;
#(
    parameter bit BRIDGE = 1'b1,
    parameter int AW     = 5
) (
    input  logic [AW-1:0] addr,
    output reg_id_e       id
);
    localparam logic [AW-1:0] WIN = AW'(BRIDGE ? WIN_BRIDGE : WIN_LEGACY);

    always_comb begin
        id = RG_NONE;
        if (addr < WIN) begin
            if (addr == AW'(OFS_UP))        id = RG_UP;
            else if (addr == AW'(OFS_DOWN)) id = RG_DOWN;
            else if (addr == AW'(OFS_EJ))   id = RG_EJ;
            else if (addr == AW'(OFS_RMV))  id = RG_RMV;
            else if (addr == AW'(OFS_SEL))  id = RG_SEL;
        end else if (addr == AW'(OFS_STS)) begin
            id = RG_STS;
        end else if (addr == AW'(OFS_EN)) begin
            id = RG_EN;
        end
    end
endmodule

// File: rtl/slot_evt_lowbit.sv
module slot_evt_lowbit #(
    parameter  int W  = 32,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/slot_evt_bank.sv
module slot_evt_bank
    import slot_evt_pkg::*;
#(
    parameter  int NUM_BUS  = 4,
    parameter  int NUM_SLOT = 32,
    parameter  bit BRIDGE   = 1'b1,
    parameter  int AW       = 5,
    parameter  int DW       = 32,
    localparam int BUS_W    = $clog2(NUM_BUS),
    localparam int EBUS_W   = BUS_W + 1,
    localparam int SLOT_W   = $clog2(NUM_SLOT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [AW-1:0]                reg_addr,
    input  logic [DW-1:0]                reg_wdata,
    output logic [DW-1:0]                reg_rdata,
    input  logic                         evt_valid,
    input  logic                         evt_remove,
    input  logic                         evt_hot,
    input  logic [EBUS_W-1:0]            evt_bus,
    input  logic [SLOT_W-1:0]            evt_slot,
    output logic                         evt_err,
    input  logic [NUM_BUS*NUM_SLOT-1:0]  fixed_slots,
    input  logic                         plat_reset,
    output logic                         eject_valid,
    output logic [BUS_W-1:0]             eject_bus,
    output logic [SLOT_W-1:0]            eject_slot,
    output logic                         irq
);
    typedef struct packed {
        logic [NUM_BUS-1:0][NUM_SLOT-1:0] up;
        logic [NUM_BUS-1:0][NUM_SLOT-1:0] dn;
        logic [DW-1:0]                    sel;
        logic                             drain;
        logic                             sts;
        logic                             en;
        logic [DW-1:0]                    rdata;
        logic                             ej_v;
        logic [BUS_W-1:0]                 ej_bus;
        logic [SLOT_W-1:0]                ej_slot;
        logic                             err;
        logic                             irq;
    } state_t;

    state_t st_d, st_q;
    reg_id_e acc_id;

    // address decode, window length chosen by mode
    slot_evt_decode #(.BRIDGE(BRIDGE), .AW(AW)) u_dec (
        .addr (reg_addr),
        .id   (acc_id)
    );

    // lowest set bit of the eject write data
    logic              wr_any;
    logic [SLOT_W-1:0] wr_slot;
    slot_evt_lowbit #(.W(NUM_SLOT)) u_wr_low (
        .vec (reg_wdata[NUM_SLOT-1:0]),
        .any (wr_any),
        .idx (wr_slot)
    );

    // drain walk: lowest bus holding a removal, then its lowest slot
    logic [NUM_BUS-1:0] bus_busy;
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_busy
        assign bus_busy[b] = |st_q.dn[b];
    end

    logic              dr_bus_any;
    logic [BUS_W-1:0]  dr_bus;
    logic              dr_slot_any;
    logic [SLOT_W-1:0] dr_slot;
    slot_evt_lowbit #(.W(NUM_BUS)) u_dr_bus (
        .vec (bus_busy),
        .any (dr_bus_any),
        .idx (dr_bus)
    );
    slot_evt_lowbit #(.W(NUM_SLOT)) u_dr_slot (
        .vec (st_q.dn[dr_bus]),
        .any (dr_slot_any),
        .idx (dr_slot)
    );

    logic             sel_ok;
    logic [BUS_W-1:0] sel_idx;
    logic             ev_bus_ok;
    logic [BUS_W-1:0] ev_idx;
    assign sel_ok    = st_q.sel < DW'(NUM_BUS);
    assign sel_idx   = st_q.sel[BUS_W-1:0];
    assign ev_bus_ok = BRIDGE ? (evt_bus < EBUS_W'(NUM_BUS)) : (evt_bus == '0);
    assign ev_idx    = evt_bus[BUS_W-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.ej_v = 1'b0;
        st_d.err  = 1'b0;

        // register reads
        if (reg_rd) begin
            st_d.rdata = '0;
            unique case (acc_id)
                RG_UP: if (sel_ok) begin
                    st_d.rdata[NUM_SLOT-1:0] = st_q.up[sel_idx];
                    if (BRIDGE) st_d.up[sel_idx] = '0;
                end
                RG_DOWN: if (sel_ok) st_d.rdata[NUM_SLOT-1:0] = st_q.dn[sel_idx];
                RG_RMV:  if (sel_ok) st_d.rdata[NUM_SLOT-1:0] =
                             ~fixed_slots[int'(sel_idx)*NUM_SLOT +: NUM_SLOT];
                RG_SEL:  st_d.rdata = st_q.sel;
                RG_STS:  st_d.rdata[STS_BIT] = st_q.sts;
                RG_EN:   st_d.rdata[STS_BIT] = st_q.en;
                default: st_d.rdata = '0;
            endcase
        end

        // reset drain has priority over software ejects
        if (st_q.drain) begin
            if (dr_bus_any && dr_slot_any) begin
                st_d.dn[dr_bus][dr_slot] = 1'b0;
                st_d.up[dr_bus][dr_slot] = 1'b0;
                st_d.ej_v    = 1'b1;
                st_d.ej_bus  = dr_bus;
                st_d.ej_slot = dr_slot;
            end else begin
                st_d.drain = 1'b0;
            end
        end else if (reg_wr && acc_id == RG_EJ && sel_ok && wr_any) begin
            st_d.dn[sel_idx][wr_slot] = 1'b0;
            st_d.up[sel_idx][wr_slot] = 1'b0;
            st_d.ej_v    = 1'b1;
            st_d.ej_bus  = sel_idx;
            st_d.ej_slot = wr_slot;
        end

        // plain register writes
        if (reg_wr) begin
            case (acc_id)
                RG_SEL:  st_d.sel = reg_wdata;
                RG_STS:  if (reg_wdata[STS_BIT]) st_d.sts = 1'b0;
                RG_EN:   st_d.en = reg_wdata[STS_BIT];
                default: ;
            endcase
        end

        // slot events, applied after clears so a new event wins
        if (evt_valid) begin
            if (!ev_bus_ok) begin
                st_d.err = 1'b1;
            end else if (evt_remove) begin
                st_d.dn[ev_idx][evt_slot] = 1'b1;
                st_d.sts = 1'b1;
            end else if (evt_hot) begin
                st_d.up[ev_idx][evt_slot] = 1'b1;
                st_d.sts = 1'b1;
            end
        end

        if (plat_reset) st_d.drain = 1'b1;

        st_d.irq = st_d.sts & st_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic drain_w;
    assign drain_w     = st_q.drain;
    assign reg_rdata   = st_q.rdata;
    assign evt_err     = st_q.err;
    assign eject_valid = st_q.ej_v;
    assign eject_bus   = st_q.ej_bus;
    assign eject_slot  = st_q.ej_slot;
    assign irq         = st_q.irq;
endmodule

// File: rtl/slot_evt_chk.sv
module slot_evt_chk
    import slot_evt_pkg::*;
#(
    parameter  int NUM_BUS = 4,
    parameter  bit BRIDGE  = 1'b1,
    parameter  int AW      = 5,
    parameter  int DW      = 32,
    localparam int EBUS_W  = $clog2(NUM_BUS) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [DW-1:0]     reg_rdata,
    input logic              evt_valid,
    input logic              evt_remove,
    input logic              evt_hot,
    input logic [EBUS_W-1:0] evt_bus,
    input logic              evt_err,
    input logic              eject_valid,
    input logic              irq,
    input logic              busy
);
    localparam logic [AW-1:0] WIN = AW'(BRIDGE ? WIN_BRIDGE : WIN_LEGACY);

    logic bad_bus;
    assign bad_bus = BRIDGE ? (evt_bus >= EBUS_W'(NUM_BUS)) : (evt_bus != '0);

    // R9
    bad_bus_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && bad_bus |=> evt_err);

    // R9
    no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_valid && bad_bus) |=> !evt_err);

    // R7
    zero_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == AW'(OFS_EJ) && reg_wdata == '0 && !busy |=> !eject_valid);

    // R11
    eject_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == AW'(OFS_EJ)) && !busy |=> !eject_valid);

    // R2
    feature_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == AW'(OFS_EJ) |=> reg_rdata == '0);

    // R4
    beyond_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr >= WIN && reg_addr < AW'(OFS_STS) |=> reg_rdata == '0);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(reg_wr || (evt_valid && (evt_remove || evt_hot))));
endmodule

bind slot_evt_bank slot_evt_chk #(
    .NUM_BUS (NUM_BUS),
    .BRIDGE  (BRIDGE),
    .AW      (AW),
    .DW      (DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .evt_valid   (evt_valid),
    .evt_remove  (evt_remove),
    .evt_hot     (evt_hot),
    .evt_bus     (evt_bus),
    .evt_err     (evt_err),
    .eject_valid (eject_valid),
    .irq         (irq),
    .busy        (drain_w)
);

// File: tb/slot_evt_bank_tb.sv
module slot_evt_bank_tb;
    localparam int NB = 4;
    localparam int NS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        reg_wr = 0, reg_rd = 0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        evt_valid = 0, evt_remove = 0, evt_hot = 0;
    logic [2:0]  evt_bus = '0;
    logic [4:0]  evt_slot = '0;
    logic [NB*NS-1:0] fixed_slots;
    logic        plat_reset = 0;

    logic [31:0] rdata, rdata_l;
    logic        err, err_l, ej_v, ej_vl, irq_o, irq_l;
    logic [1:0]  ej_b, ej_bl;
    logic [4:0]  ej_s, ej_sl;

    int checks = 0;
    int errors = 0;
    logic [31:0] d, l;

    slot_evt_bank #(.NUM_BUS(NB), .NUM_SLOT(NS), .BRIDGE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
        .evt_valid(evt_valid), .evt_remove(evt_remove), .evt_hot(evt_hot),
        .evt_bus(evt_bus), .evt_slot(evt_slot), .evt_err(err),
        .fixed_slots(fixed_slots), .plat_reset(plat_reset),
        .eject_valid(ej_v), .eject_bus(ej_b), .eject_slot(ej_s), .irq(irq_o));

    slot_evt_bank #(.NUM_BUS(NB), .NUM_SLOT(NS), .BRIDGE(1'b0)) u_leg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_l),
        .evt_valid(evt_valid), .evt_remove(evt_remove), .evt_hot(evt_hot),
        .evt_bus(evt_bus), .evt_slot(evt_slot), .evt_err(err_l),
        .fixed_slots(fixed_slots), .plat_reset(plat_reset),
        .eject_valid(ej_vl), .eject_bus(ej_bl), .eject_slot(ej_sl), .irq(irq_l));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] dv, output logic [31:0] lv);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        dv = rdata; lv = rdata_l;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic post(input logic [2:0] b, input logic [4:0] s, input logic rem, input logic hot);
        @(negedge clk);
        evt_valid = 1; evt_bus = b; evt_slot = s; evt_remove = rem; evt_hot = hot;
        @(negedge clk);
        evt_valid = 0;
    endtask

    task automatic t_reset;
        chk("R12 irq", irq_o, 0);
        chk("R12 eject", ej_v, 0);
        chk("R12 err", err, 0);
        rd(5'h00, d, l); chk("R12 up", d, 0); chk("R12 legacy up", l, 0);
        rd(5'h10, d, l); chk("R12 sel", d, 0);
    endtask

    task automatic t_map;
        rd(5'h0C, d, l);
        chk("R1 removable", d, 32'hFFFF_FFF7);
        chk("R1 legacy removable", l, 32'hFFFF_FFF7);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, d, l); chk("R1 read-only write ignored", d, 0);
        rd(5'h14, d, l); chk("R1 undecoded read", d, 0);
        rd(5'h08, d, l); chk("R2 feature read", d, 0); chk("R2 legacy feature read", l, 0);
    endtask

    task automatic t_insert;
        wr(5'h1C, 32'h2);
        post(3'd0, 5'd5, 1'b0, 1'b1);
        chk("R10 irq on insert", irq_o, 1); chk("R10 legacy irq on insert", irq_l, 1);
        rd(5'h00, d, l); chk("R5 insert bit", d, 32'h20); chk("R5 legacy insert bit", l, 32'h20);
        rd(5'h00, d, l); chk("R3 cleared on read", d, 0); chk("R3 legacy sticky", l, 32'h20);
        rd(5'h18, d, l); chk("R5 status value 2", d, 32'h2);
        wr(5'h18, 32'h2);
        chk("R10 w1c clears irq", irq_o, 0);
        rd(5'h18, d, l); chk("R10 status cleared", d, 0);
        post(3'd0, 5'd7, 1'b1, 1'b1);
        rd(5'h04, d, l); chk("R5 remove bit", d, 32'h80); chk("R5 legacy remove bit", l, 32'h80);
        chk("R5 remove raises irq", irq_o, 1);
        wr(5'h18, 32'h2);
    endtask

    task automatic t_cold;
        post(3'd0, 5'd9, 1'b0, 1'b0);
        chk("R6 cold no irq", irq_o, 0);
        rd(5'h00, d, l); chk("R6 cold no bit", d, 0); chk("R6 legacy cold no bit", l, 32'h20);
        rd(5'h18, d, l); chk("R6 cold no status", d, 0);
    endtask

    task automatic t_eject;
        post(3'd0, 5'd2, 1'b1, 1'b1);
        post(3'd0, 5'd2, 1'b0, 1'b1);
        @(negedge clk);
        reg_wr = 1; reg_addr = 5'h08; reg_wdata = 32'h84;
        @(negedge clk);
        reg_wr = 0;
        chk("R7 eject pulse", ej_v, 1); chk("R7 eject slot", ej_s, 2); chk("R7 eject bus", ej_b, 0);
        chk("R7 legacy eject slot", ej_sl, 2);
        @(negedge clk);
        chk("R7 pulse one cycle", ej_v, 0);
        rd(5'h04, d, l); chk("R7 remove cleared", d, 32'h80); chk("R7 legacy remove cleared", l, 32'h80);
        rd(5'h00, d, l); chk("R7 insert cleared", d, 0); chk("R7 legacy insert cleared", l, 32'h20);
        @(negedge clk);
        reg_wr = 1; reg_addr = 5'h08; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 0;
        chk("R7 zero data no eject", ej_v, 0);
        rd(5'h04, d, l); chk("R7 zero data keeps remove", d, 32'h80);
    endtask

    task automatic t_sel;
        wr(5'h10, 32'd1);
        rd(5'h10, d, l); chk("R1 select readback", d, 1); chk("R4 legacy select unreachable", l, 0);
        post(3'd1, 5'd4, 1'b0, 1'b1);
        chk("R9 bus 1 accepted", err, 0); chk("R4 legacy bus 1 rejected", err_l, 1);
        rd(5'h00, d, l); chk("R1 insert of bus 1", d, 32'h10); chk("R4 legacy still bus 0", l, 32'h20);
        wr(5'h10, 32'd4);
        rd(5'h04, d, l); chk("R1 out-of-range select reads zero", d, 0);
        post(3'd1, 5'd6, 1'b1, 1'b1);
        @(negedge clk);
        reg_wr = 1; reg_addr = 5'h08; reg_wdata = 32'h40;
        @(negedge clk);
        reg_wr = 0;
        chk("R8 eject ignored", ej_v, 0); chk("R4 legacy eject on bus 0", ej_vl, 1);
        chk("R4 legacy eject slot", ej_sl, 6);
        wr(5'h10, 32'd1);
        rd(5'h04, d, l); chk("R8 remove kept", d, 32'h40); chk("R7 legacy other slot kept", l, 32'h80);
    endtask

    task automatic t_badbus;
        wr(5'h18, 32'h2);
        post(3'd5, 5'd3, 1'b0, 1'b1);
        chk("R9 error pulse", err, 1); chk("R9 legacy error pulse", err_l, 1);
        @(negedge clk);
        chk("R9 error one cycle", err, 0);
        rd(5'h18, d, l); chk("R9 no status", d, 0); chk("R9 legacy no status", l, 0);
        chk("R9 no irq", irq_o, 0);
    endtask

    task automatic t_enable;
        wr(5'h1C, 32'h0);
        post(3'd0, 5'd1, 1'b0, 1'b1);
        chk("R10 masked irq", irq_o, 0);
        rd(5'h18, d, l); chk("R10 status set while masked", d, 32'h2);
        wr(5'h1C, 32'h2);
        chk("R10 enable raises irq", irq_o, 1); chk("R10 legacy enable raises irq", irq_l, 1);
        wr(5'h18, 32'h2);
        chk("R10 irq cleared", irq_o, 0);
    endtask

    task automatic t_drain;
        int n = 0, nl = 0;
        logic [6:0] seq [0:3];
        logic [6:0] seql [0:3];
        @(negedge clk);
        plat_reset = 1;
        @(negedge clk);
        plat_reset = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ej_v  && n  < 4) begin seq[n]   = {ej_b, ej_s};   n++;  end
            if (ej_vl && nl < 4) begin seql[nl] = {ej_bl, ej_sl}; nl++; end
        end
        chk("R11 eject count", n, 2);
        chk("R11 legacy eject count", nl, 1);
        if (n >= 2) begin
            chk("R11 first bus 0 slot 7", seq[0], {2'd0, 5'd7});
            chk("R11 second bus 1 slot 6", seq[1], {2'd1, 5'd6});
        end
        if (nl >= 1) chk("R11 legacy bus 0 slot 7", seql[0], {2'd0, 5'd7});
        rd(5'h04, d, l); chk("R11 bus 1 removes gone", d, 0); chk("R11 legacy removes gone", l, 0);
        wr(5'h10, 32'd0);
        rd(5'h04, d, l); chk("R11 bus 0 removes gone", d, 0);
    endtask

    bit done = 0;
    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        fixed_slots = '0;
        fixed_slots[3] = 1'b1;
        fixed_slots[NS + 0] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_map();
        t_insert();
        t_cold();
        t_eject();
        t_sel();
        t_badbus();
        t_enable();
        t_drain();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule